// File: doc/BRIEF.md
# PWM Channel with Two-Stage Tick Divider

This block produces one pulse-width-modulated output. It works in the domain of a fast core clock. Two slower input clocks arrive as plain signals and the core clock samples them. A source-select bit picks one of the two. Every rising edge of the chosen input is one source tick. The source ticks pass through a power-of-two divider. The result then passes through a divide-by-(K+1) prescaler, which gives the counting tick.

A 16-bit counter steps on each counting tick and wraps at the programmed period. The output is at its active level while the count is below the programmed active count. Period and active count arrive together in one 32-bit word. The channel takes a new word only at a period boundary. Software can read the counter at any time.

A bypass mode skips the counter. It forwards the sampled level of the chosen input to the pin, which gives a square wave at the input frequency. The channel runs only while both the gate bit and the enable bit are set. Otherwise the pin rests at its inactive level.

Top module: `pwm_prescaled_channel`

## Requirements
- R1: `src_sel_i`=0 takes ticks from `src0_clk_i`, the default oscillator input. `src_sel_i`=1 takes ticks from `src1_clk_i`. A tick is a rising edge of the chosen input as seen by two successive core-clock samples. The select may change only while the channel is stopped.
- R2: The first divider stage passes one tick out of every 2^M source ticks, where M is `div_exp_i`. Any value of M above 8 acts as 8. Two counter steps are never closer together than two core cycles.
- R3: The second stage passes one tick out of every K+1 first-stage ticks, where K is `prescale_i` (0 to 255).
- R4: `cycle_word_i[31:16]` is the period P in counting ticks. `cycle_word_i[15:0]` is the active count A.
- R5: `count_o` steps by one on each counting tick. It returns to 0 on the tick that would make it reach P. A period of 0 behaves like a period of 1. Between ticks the count holds.
- R6: When `polarity_i`=1 the pin is high during the active part of the period. When `polarity_i`=0 the pin is low during the active part. The active part is every count below A.
- R7: The channel runs only when `gate_i` and `enable_i` are both 1. While it is stopped, `count_o` and both divider stages are zero, and `pwm_o` is at the inactive level (the inverse of `polarity_i`).
- R8: When the channel runs with `bypass_i`=1, `pwm_o` equals the chosen input as sampled on the previous core-clock edge. The counter keeps running underneath.
- R9: A changed `cycle_word_i` takes effect at the next wrap of the counter, or at once while the channel is stopped. A period already in progress finishes with the old values.
- R10: A=0 gives a constant inactive output. A≥P gives a constant active output.
- R11: During synchronous active-low reset and right after it, `count_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src0_clk_i | input | 1 | Input clock 0 (default oscillator), sampled |
| src1_clk_i | input | 1 | Input clock 1, sampled |
| src_sel_i | input | 1 | Source select |
| div_exp_i | input | 4 | Power-of-two divider exponent M |
| prescale_i | input | 8 | Prescale value K (divide by K+1) |
| cycle_word_i | input | 32 | Period (upper half) and active count (lower half) |
| polarity_i | input | 1 | 1: active high |
| gate_i | input | 1 | Channel clock gate |
| enable_i | input | 1 | Channel enable |
| bypass_i | input | 1 | Forward the chosen input to the pin |
| pwm_o | output | 1 | PWM pin |
| count_o | output | 16 | Current counter value |

## Verification
The bench uses the package defaults: a 16-bit counter, a 4-bit exponent clamped at 8, and an 8-bit prescale. The two inputs toggle every two and every three core cycles. With these values an exponent of 12 gives a full divide-by-256 in about a thousand cycles, so the clamp can be seen in a short run. Small periods, such as 2 to 5 counting ticks, bring several wraps into each phase. That covers shadow loading at the boundary, both saturating duty cases and both polarities.

// File: rtl/pwmc_pkg.sv
// Shared constants and the packed period/active word layout for the PWM channel.
package pwmc_pkg;
    localparam int PWMC_CNT_W   = 16;  // counter and compare width
    localparam int PWMC_EXP_W   = 4;   // divider exponent field width
    localparam int PWMC_MAX_EXP = 8;   // largest honoured exponent
    localparam int PWMC_PRE_W   = 8;   // prescale field width
    localparam int PWMC_NSRC    = 2;   // number of selectable input clocks

    // Upper half is the period, lower half the active count.
    typedef struct packed {
        logic [PWMC_CNT_W-1:0] period;
        logic [PWMC_CNT_W-1:0] active;
    } pwmc_word_t;
endpackage

// File: rtl/pwmc_src_sel.sv
// Samples every input clock with the core clock, picks one, and flags its rising edges.
// Assumes each input is slower than half the core clock. The select is stable while running.
module pwmc_src_sel #(
    parameter int NSRC  = 2,
    localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             level_o,
    output logic             rise_o
);
    logic [NSRC-1:0] smp_q;
    logic [NSRC-1:0] prev_q;

    // One sample stage and one history stage per input.
    for (genvar g = 0; g < NSRC; g++) begin : g_smp
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                smp_q[g]  <= 1'b0;
                prev_q[g] <= 1'b0;
            end else begin
                smp_q[g]  <= src_i[g];
                prev_q[g] <= smp_q[g];
            end
        end
    end

    // Pick the chosen input and detect its rising edge.
    always_comb begin
        level_o = smp_q[sel_i];
        rise_o  = smp_q[sel_i] & ~prev_q[sel_i];
    end
endmodule

// File: rtl/pwmc_prescaler.sv
// Two cascaded dividers: pass one of every 2^M source ticks, then one of every K+1.
// Assumes nothing about field stability. Both compares use >= so a lowered limit does not stall.
module pwmc_prescaler #(
    parameter int EXP_W   = 4,
    parameter int MAX_EXP = 8,
    parameter int PRE_W   = 8,
    localparam int DIV_W  = (MAX_EXP > 0) ? MAX_EXP : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             rise_i,
    input  logic [EXP_W-1:0] exp_i,
    input  logic [PRE_W-1:0] pre_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] div_q;
    logic [PRE_W-1:0] pre_q;
    logic [EXP_W-1:0] exp_eff;
    logic [DIV_W:0]   pow_val;
    logic [DIV_W-1:0] div_lim;
    logic             stage1;

    // Clamp the exponent and derive the first-stage limit.
    always_comb begin
        exp_eff = (exp_i > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : exp_i;
        pow_val = (DIV_W+1)'(1) << exp_eff;
        div_lim = DIV_W'(pow_val - (DIV_W+1)'(1));
        stage1  = run_i & rise_i & (div_q >= div_lim);
        tick_o  = stage1 & (pre_q >= pre_i);
    end

    // First stage: count source ticks up to the 2^M limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            div_q <= '0;
        end else if (rise_i) begin
            div_q <= (div_q >= div_lim) ? '0 : div_q + 1'b1;
        end
    end

    // Second stage: count first-stage ticks up to K.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            pre_q <= '0;
        end else if (stage1) begin
            pre_q <= (pre_q >= pre_i) ? '0 : pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwmc_period_core.sv
// Period counter with shadowed period and active values, and the duty compare.
// While stopped, the shadows follow the input word. While running, they load only at a wrap.
module pwmc_period_core
    import pwmc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run_i,
    input  logic                  tick_i,
    input  pwmc_word_t            word_i,
    output logic [PWMC_CNT_W-1:0] count_o,
    output logic                  active_o
);
    logic [PWMC_CNT_W-1:0] cnt_q;
    pwmc_word_t            shd_q;
    logic                  wrap;

    // Wrap when the next count would reach the period (period 0 acts as 1).
    always_comb begin
        wrap     = ({1'b0, cnt_q} + 1'b1) >= {1'b0, shd_q.period};
        active_o = cnt_q < shd_q.active;
        count_o  = cnt_q;
    end

    // Counter: hold at zero while stopped, step on ticks, wrap at the period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end

    // Shadow: follow the input while stopped, reload at each wrap while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shd_q <= '0;
        end else if (!run_i || (tick_i && wrap)) begin
            shd_q <= word_i;
        end
    end
endmodule

// File: rtl/pwm_prescaled_channel.sv
// Top of the PWM channel: source pick, two-stage divider, period core and pin mux.
// The pin is combinational from registered state and the mode inputs.
module pwm_prescaled_channel
    import pwmc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  src0_clk_i,
    input  logic                  src1_clk_i,
    input  logic                  src_sel_i,
    input  logic [PWMC_EXP_W-1:0] div_exp_i,
    input  logic [PWMC_PRE_W-1:0] prescale_i,
    input  logic [31:0]           cycle_word_i,
    input  logic                  polarity_i,
    input  logic                  gate_i,
    input  logic                  enable_i,
    input  logic                  bypass_i,
    output logic                  pwm_o,
    output logic [PWMC_CNT_W-1:0] count_o
);
    logic run;
    logic src_level;
    logic src_rise;
    logic cnt_tick;
    logic in_active;

    assign run = gate_i & enable_i;

    pwmc_src_sel #(.NSRC(PWMC_NSRC)) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   ({src1_clk_i, src0_clk_i}),
        .sel_i   (src_sel_i),
        .level_o (src_level),
        .rise_o  (src_rise)
    );

    pwmc_prescaler #(
        .EXP_W   (PWMC_EXP_W),
        .MAX_EXP (PWMC_MAX_EXP),
        .PRE_W   (PWMC_PRE_W)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .rise_i (src_rise),
        .exp_i  (div_exp_i),
        .pre_i  (prescale_i),
        .tick_o (cnt_tick)
    );

    pwmc_period_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .tick_i   (cnt_tick),
        .word_i   (pwmc_word_t'(cycle_word_i)),
        .count_o  (count_o),
        .active_o (in_active)
    );

    // Pin mux: inactive when stopped, raw source in bypass, else the compare with polarity.
    always_comb begin
        if (!run)          pwm_o = ~polarity_i;
        else if (bypass_i) pwm_o = src_level;
        else               pwm_o = in_active ? polarity_i : ~polarity_i;
    end
endmodule

// File: rtl/pwmc_checker.sv
// Port-level properties of the PWM channel, bound to the top module.
module pwmc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        src0_clk_i,
    input logic        src1_clk_i,
    input logic        src_sel_i,
    input logic        gate_i,
    input logic        enable_i,
    input logic        bypass_i,
    input logic        pwm_o,
    input logic [15:0] count_o
);
    logic run;
    assign run = gate_i && enable_i;

    // R7
    stopped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (count_o == 16'd0));

    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o != $past(count_o)) |-> ((count_o == $past(count_o) + 16'd1) || (count_o == 16'd0)));

    // R8
    bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && bypass_i && $past(run && bypass_i) && $stable(src_sel_i))
            |-> (pwm_o == $past(src_sel_i ? src1_clk_i : src0_clk_i)));

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && $past(run, 2) && $stable(src_sel_i) && (count_o != $past(count_o)))
            |-> ($past(count_o) == $past(count_o, 2)));
endmodule

bind pwm_prescaled_channel pwmc_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src0_clk_i (src0_clk_i),
    .src1_clk_i (src1_clk_i),
    .src_sel_i  (src_sel_i),
    .gate_i     (gate_i),
    .enable_i   (enable_i),
    .bypass_i   (bypass_i),
    .pwm_o      (pwm_o),
    .count_o    (count_o)
);

// File: tb/pwm_prescaled_channel_tb.sv
// Bench: behavioural reference model stepped on every clock and compared at each falling edge.
module pwm_prescaled_channel_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src0 = 1'b0, src1 = 1'b0;
    logic        sel = 1'b0;
    logic [3:0]  mexp = '0;
    logic [7:0]  kpre = '0;
    logic [31:0] word = '0;
    logic        pol = 1'b1, gate = 1'b0, en = 1'b0, byp = 1'b0;
    logic        pwm;
    logic [15:0] cnt;

    int tests = 0, fails = 0, cycles = 0;
    bit comparing = 1'b0, done = 1'b0;
    string cur_req = "R11";

    // Reference state (behavioural integers)
    int m_s0 = 0, m_s1 = 0, m_p0 = 0, m_p1 = 0;
    int m_div = 0, m_pre = 0, m_cnt = 0, m_per = 0, m_act = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_prescaled_channel u_dut (
        .clk(clk), .rst_n(rst_n), .src0_clk_i(src0), .src1_clk_i(src1),
        .src_sel_i(sel), .div_exp_i(mexp), .prescale_i(kpre), .cycle_word_i(word),
        .polarity_i(pol), .gate_i(gate), .enable_i(en), .bypass_i(byp),
        .pwm_o(pwm), .count_o(cnt)
    );

    // Source stimulus: src0 toggles every 2 cycles, src1 every 3.
    always @(posedge clk) begin
        #2;
        if (cycles % 2 == 0) src0 = ~src0;
        if (cycles % 3 == 0) src1 = ~src1;
    end

    // Reference model step at each rising edge.
    always @(posedge clk) begin
        int rise, e, lim, tick;
        cycles++;
        if (!rst_n) begin
            m_s0 = 0; m_s1 = 0; m_p0 = 0; m_p1 = 0;
            m_div = 0; m_pre = 0; m_cnt = 0; m_per = 0; m_act = 0;
        end else begin
            rise = sel ? (m_s1 && !m_p1) : (m_s0 && !m_p0);
            m_p0 = m_s0; m_p1 = m_s1; m_s0 = src0; m_s1 = src1;
            tick = 0;
            if (!(gate && en)) begin
                m_div = 0; m_pre = 0; m_cnt = 0;
                m_per = word[31:16]; m_act = word[15:0];
            end else if (rise) begin
                e = (mexp > 8) ? 8 : mexp;
                lim = (1 << e) - 1;
                if (m_div >= lim) begin
                    m_div = 0;
                    if (m_pre >= kpre) begin m_pre = 0; tick = 1; end
                    else m_pre++;
                end else m_div++;
            end
            if (tick) begin
                if (m_cnt + 1 >= m_per) begin
                    m_cnt = 0; m_per = word[31:16]; m_act = word[15:0];
                end else m_cnt++;
            end
        end
    end

    // Compare at the falling edge.
    always @(negedge clk) begin
        int exp_pin, lvl;
        if (comparing && !done) begin
            lvl = sel ? m_s1 : m_s0;
            if (!(gate && en))  exp_pin = !pol;
            else if (byp)       exp_pin = lvl;
            else                exp_pin = (m_cnt < m_act) ? pol : !pol;
            tests++;
            if (pwm !== 1'(exp_pin) || cnt !== 16'(m_cnt)) begin
                fails++;
                $display("FAIL %s: pwm=%0b cnt=%0d expected pwm=%0b cnt=%0d",
                         cur_req, pwm, cnt, exp_pin, m_cnt);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #2;
    endtask

    initial begin
        // R11: reset state
        wait_cyc(5);
        comparing = 1'b1;
        @(negedge clk);
        tests++;
        if (cnt !== 16'd0 || pwm !== 1'b0) begin
            fails++;
            $display("FAIL R11: cnt=%0d pwm=%0b expected cnt=0 pwm=0", cnt, pwm);
        end
        wait_cyc(1);
        rst_n = 1'b1;
        wait_cyc(5);

        // R7: stopped with only one of gate/enable set
        cur_req = "R7";
        word = {16'd4, 16'd1};
        gate = 1'b1; en = 1'b0; wait_cyc(30);
        gate = 1'b0; en = 1'b1; wait_cyc(30);

        // R2 R3 R4 R5: M=1, K=2, period 4, active 1 from src0 (R1 default)
        cur_req = "R2/R3/R4/R5";
        sel = 1'b0; mexp = 4'd1; kpre = 8'd2;
        gate = 1'b1; en = 1'b1; wait_cyc(300);

        // R9: new word mid-period waits for the wrap
        cur_req = "R9";
        word = {16'd3, 16'd2}; wait_cyc(200);

        // R6: inverted polarity
        cur_req = "R6";
        pol = 1'b0; wait_cyc(100);
        pol = 1'b1;

        // R10: zero active, then active above period
        cur_req = "R10";
        word = {16'd3, 16'd0}; wait_cyc(100);
        word = {16'd3, 16'd5}; wait_cyc(100);

        // R2: exponent above 8 clamps to 256
        cur_req = "R2 clamp";
        mexp = 4'd12; kpre = 8'd0; word = {16'd2, 16'd1}; wait_cyc(3000);

        // R1: switch to second input while stopped
        cur_req = "R1";
        en = 1'b0; wait_cyc(3);
        sel = 1'b1; mexp = 4'd0; kpre = 8'd0; word = {16'd5, 16'd2};
        wait_cyc(3);
        en = 1'b1; wait_cyc(200);

        // R7: stop drops the pin and counter, restart afresh
        cur_req = "R7 restart";
        gate = 1'b0; wait_cyc(20);
        gate = 1'b1; wait_cyc(60);

        // R8: bypass on both sources
        cur_req = "R8";
        byp = 1'b1; wait_cyc(100);
        en = 1'b0; wait_cyc(3); sel = 1'b0; wait_cyc(3); en = 1'b1;
        wait_cyc(100);
        byp = 1'b0; wait_cyc(50);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule